// File: doc/BRIEF.md
# Multi-Sensor Thermal Monitor

The block gathers temperature samples from nine on-die sensors: one beside each of eight cores and one in the shared uncore logic. Each sensor delivers an 8-bit unsigned reading in degrees Celsius together with a one-cycle valid strobe. A sensor next to a power-gated core goes on reporting, so every strobe is accepted whatever the state of the core. The block holds the latest reading of each sensor. From the sensors that have reported at least once since reset it derives a running maximum and a truncated mean. All eleven values can be read through a simple combinational read port that a system management bus agent polls.

Two graded responses are derived from the maximum. At the alert threshold the block asks the power controller to lower voltage and frequency. The request is released only after the maximum falls below the threshold minus a programmable hysteresis. At the critical threshold the block raises a shutdown request for the clock generator and a power-off request for the external voltage regulator. Both shutdown requests stay set until reset.

Top module: `thermal_monitor`

## Requirements
- R1: A valid strobe on sensor i loads that sensor's 8-bit sample into its own register and into no other. Several strobes in one cycle each load their own sensor. Read addresses 0 to 8 return sensors 0 to 8, and a sensor that has not yet reported reads 0.
- R2: Read address 9 returns the maximum over the sensors that have reported since reset, or 0 when none has.
- R3: Read address 10 returns the sum of the reported sensors' values divided by their number, truncated, or 0 when none has reported. Sensors that have not reported count in neither the sum nor the divisor.
- R4: Read addresses 11 to 15 return 0.
- R5: `vf_reduce_req` rises when at least one sensor has reported and the maximum is greater than or equal to `alert_level`.
- R6: Once set, `vf_reduce_req` falls only when the maximum is below `alert_level - hyst_amount`. The difference saturates at 0, so a hysteresis larger than the threshold holds the request until reset.
- R7: `clkgen_off` and `vreg_off` rise together when at least one sensor has reported and the maximum is greater than or equal to `crit_level`. They stay high until reset, whatever the later readings.
- R8: A sample appears on the read port one edge after its strobe edge. The maximum and mean follow one edge later, and the responses one edge after that.
- R9: After reset, every read address returns 0 and all three request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 9 | One strobe per sensor, bit i for sensor i |
| smp_data | input | 72 | Samples, sensor i in bits [8i+7:8i] |
| alert_level | input | 8 | Alert threshold, degrees C |
| hyst_amount | input | 8 | Alert release hysteresis, degrees C |
| crit_level | input | 8 | Critical threshold, degrees C |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| vf_reduce_req | output | 1 | Request to lower voltage and frequency |
| clkgen_off | output | 1 | Sticky clock generator shutdown |
| vreg_off | output | 1 | Sticky external regulator power-off request |

## Verification
The hardest case to reach is a divisor below nine. Only the first few strobes after reset, before every sensor has reported, produce it. The bench therefore starts each run from reset and brings sensors in one at a time and in pseudo-random subsets, recomputing the expected maximum and mean arithmetically for each partial population. The hysteresis band is then walked degree by degree across the release and set points. The critical path is driven last, so that the sticky shutdown can be observed surviving a return to cool readings before a reset clears it.

// File: rtl/thermal_pkg.sv
// Shared constants and types for the thermal monitor.
package thermal_pkg;
    localparam int unsigned DEF_SENSORS = 9;
    localparam int unsigned DEF_TEMP_W  = 8;

    // Graded response produced by the response controller.
    typedef struct packed {
        logic alert;   // lower voltage/frequency request
        logic halt;    // sticky shutdown request
    } resp_t;
endpackage

// File: rtl/sensor_bank.sv
// sensor_bank: holds the latest sample of each sensor and a flag recording
// whether that sensor has reported since reset.
// Assumes: each strobe is a single-cycle qualifier for its own data lane.
module sensor_bank #(
    parameter int N = 9,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   valid_i,
    input  logic [N*W-1:0] data_i,
    output logic [N*W-1:0] temps_o,
    output logic [N-1:0]   seen_o
);
    logic [N*W-1:0] temps_q;
    logic [N-1:0]   seen_q;

    for (genvar i = 0; i < N; i++) begin : g_lane
        // Capture the lane's sample and mark it reported on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                temps_q[i*W +: W] <= '0;
                seen_q[i]         <= 1'b0;
            end else if (valid_i[i]) begin
                temps_q[i*W +: W] <= data_i[i*W +: W];
                seen_q[i]         <= 1'b1;
            end
        end

        // R1: a reported sensor never drops out of the population.
        assert_seen_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
            seen_q[i] |=> seen_q[i]);

        // R1: without a strobe the lane holds its value.
        assert_lane_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_i[i] |=> $stable(temps_q[i*W +: W]));
    end

    assign temps_o = temps_q;
    assign seen_o  = seen_q;
endmodule

// File: rtl/stats_unit.sv
// stats_unit: registers the maximum and truncated mean over the sensors that
// have reported since reset; both read 0 while no sensor has reported.
// Assumes: inputs come straight from registers, so one divide per cycle fits.
module stats_unit #(
    parameter int N = 9,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N*W-1:0] temps_i,
    input  logic [N-1:0]   seen_i,
    output logic [W-1:0]   peak_o,
    output logic [W-1:0]   avg_o,
    output logic           any_o
);
    localparam int CNT_W = $clog2(N + 1);
    localparam int SUM_W = W + $clog2(N);

    // Restoring division of an unsigned sum by a non-zero count.
    function automatic logic [SUM_W-1:0] udiv(input logic [SUM_W-1:0] num,
                                               input logic [CNT_W-1:0] den);
        logic [SUM_W:0]   rem;
        logic [SUM_W-1:0] quo;
        rem = '0;
        quo = '0;
        for (int b = SUM_W - 1; b >= 0; b--) begin
            rem = {rem[SUM_W-1:0], num[b]};
            if (rem >= {{(SUM_W + 1 - CNT_W){1'b0}}, den}) begin
                rem    = rem - {{(SUM_W + 1 - CNT_W){1'b0}}, den};
                quo[b] = 1'b1;
            end
        end
        return quo;
    endfunction

    logic [W-1:0]     max_c;
    logic [SUM_W-1:0] sum_c;
    logic [CNT_W-1:0] cnt_c;
    logic [SUM_W-1:0] quo_c;

    // Reduce the reported lanes to a maximum, a sum and a population count.
    always_comb begin
        max_c = '0;
        sum_c = '0;
        cnt_c = '0;
        for (int i = 0; i < N; i++) begin
            if (seen_i[i]) begin
                if (temps_i[i*W +: W] > max_c) max_c = temps_i[i*W +: W];
                sum_c = sum_c + {{(SUM_W - W){1'b0}}, temps_i[i*W +: W]};
                cnt_c = cnt_c + CNT_W'(1);
            end
        end
        quo_c = (cnt_c == '0) ? '0 : udiv(sum_c, cnt_c);
    end

    logic [W-1:0] peak_q, avg_q;
    logic         any_q;

    // Register the statistics once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_q <= '0;
            avg_q  <= '0;
            any_q  <= 1'b0;
        end else begin
            peak_q <= max_c;
            avg_q  <= quo_c[W-1:0];
            any_q  <= (cnt_c != '0);
        end
    end

    // R3: a mean never exceeds the maximum of the same population.
    assert_avg_le_peak_R3: assert property (@(posedge clk) disable iff (!rst_n)
        avg_q <= peak_q);

    // R2: with nothing reported the statistics stay zero.
    assert_empty_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !any_q |-> (peak_q == '0 && avg_q == '0));

    assign peak_o = peak_q;
    assign avg_o  = avg_q;
    assign any_o  = any_q;
endmodule

// File: rtl/response_ctrl.sv
// response_ctrl: turns the maximum into a hysteretic alert and a sticky halt.
// Assumes: thresholds are quasi-static; both responses need a reported sensor.
module response_ctrl #(
    parameter int W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       peak_i,
    input  logic               any_i,
    input  logic [W-1:0]       alert_level_i,
    input  logic [W-1:0]       hyst_i,
    input  logic [W-1:0]       crit_level_i,
    output thermal_pkg::resp_t resp_o
);
    logic [W-1:0] release_lvl;
    logic         alert_q, halt_q;

    // Saturating release point below the alert threshold.
    always_comb begin
        release_lvl = (hyst_i >= alert_level_i) ? '0 : alert_level_i - hyst_i;
    end

    // Set the alert at the threshold, clear it below the release point.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  alert_q <= 1'b0;
        else if (any_i && peak_i >= alert_level_i)   alert_q <= 1'b1;
        else if (!any_i || peak_i < release_lvl)     alert_q <= 1'b0;
    end

    // Latch the halt at the critical limit; only reset releases it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  halt_q <= 1'b0;
        else if (any_i && peak_i >= crit_level_i)    halt_q <= 1'b1;
    end

    // R7: once raised, the halt stays raised.
    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |=> halt_q);

    // R5: the alert only rises on a maximum at or above the threshold.
    assert_alert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_q) |-> $past(peak_i >= alert_level_i));

    // R6: the alert only falls on a maximum below the release point.
    assert_alert_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_q) |-> $past(!any_i || peak_i < release_lvl));

    assign resp_o.alert = alert_q;
    assign resp_o.halt  = halt_q;
endmodule

// File: rtl/thermal_monitor.sv
// thermal_monitor: top of the nine-sensor thermal monitor. Samples feed a
// bank, statistics are registered, responses follow, and a combinational
// read port exposes sensors, maximum and mean.
// Assumes: rd_addr is driven synchronously by the management agent.
module thermal_monitor #(
    parameter int N  = thermal_pkg::DEF_SENSORS,
    parameter int W  = thermal_pkg::DEF_TEMP_W,
    localparam int AW = $clog2(N + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   smp_valid,
    input  logic [N*W-1:0] smp_data,
    input  logic [W-1:0]   alert_level,
    input  logic [W-1:0]   hyst_amount,
    input  logic [W-1:0]   crit_level,
    input  logic [AW-1:0]  rd_addr,
    output logic [W-1:0]   rd_data,
    output logic           vf_reduce_req,
    output logic           clkgen_off,
    output logic           vreg_off
);
    localparam int PEAK_ADDR = N;
    localparam int AVG_ADDR  = N + 1;

    logic [N*W-1:0]     temps;
    logic [N-1:0]       seen;
    logic [W-1:0]       peak, avg;
    logic               any_seen;
    thermal_pkg::resp_t resp;

    sensor_bank #(.N(N), .W(W)) u_bank (
        .clk(clk), .rst_n(rst_n), .valid_i(smp_valid), .data_i(smp_data),
        .temps_o(temps), .seen_o(seen));

    stats_unit #(.N(N), .W(W)) u_stats (
        .clk(clk), .rst_n(rst_n), .temps_i(temps), .seen_i(seen),
        .peak_o(peak), .avg_o(avg), .any_o(any_seen));

    response_ctrl #(.W(W)) u_resp (
        .clk(clk), .rst_n(rst_n), .peak_i(peak), .any_i(any_seen),
        .alert_level_i(alert_level), .hyst_i(hyst_amount),
        .crit_level_i(crit_level), .resp_o(resp));

    // Select a sensor, the maximum, the mean, or zero for unused addresses.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++)
            if (rd_addr == AW'(i)) rd_data = temps[i*W +: W];
        if (rd_addr == AW'(PEAK_ADDR)) rd_data = peak;
        if (rd_addr == AW'(AVG_ADDR))  rd_data = avg;
    end

    assign vf_reduce_req = resp.alert;
    assign clkgen_off    = resp.halt;
    assign vreg_off      = resp.halt;

    // R7: both shutdown requests always move together.
    assert_halt_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clkgen_off == vreg_off);

    // R4: addresses beyond the mean read zero.
    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > AW'(AVG_ADDR)) |-> (rd_data == '0));
endmodule

// File: tb/tb_thermal_monitor.sv
module tb_thermal_monitor;
    localparam int N = 9;
    localparam int W = 8;

    logic           clk = 0;
    logic           rst_n = 0;
    logic [N-1:0]   smp_valid = '0;
    logic [N*W-1:0] smp_data = '0;
    logic [W-1:0]   alert_level = 0, hyst_amount = 0, crit_level = 0;
    logic [3:0]     rd_addr = 0;
    logic [W-1:0]   rd_data;
    logic           vf_reduce_req, clkgen_off, vreg_off;

    thermal_monitor dut (.*);

    always #5 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;
    int mval [N];
    bit mseen [N];

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(int a, output int v);
        rd_addr = a[3:0];
        #1;
        v = int'(rd_data);
    endtask

    function automatic int exp_peak();
        int p = 0;
        for (int i = 0; i < N; i++) if (mseen[i] && mval[i] > p) p = mval[i];
        return p;
    endfunction

    function automatic int exp_avg();
        int s = 0, c = 0;
        for (int i = 0; i < N; i++) if (mseen[i]) begin s += mval[i]; c++; end
        return (c == 0) ? 0 : s / c;
    endfunction

    // Drive a strobe mask with values for one cycle, then let it settle.
    task automatic push(logic [N-1:0] mask, int vals [N]);
        @(negedge clk);
        smp_valid = mask;
        for (int i = 0; i < N; i++) begin
            smp_data[i*W +: W] = vals[i][7:0];
            if (mask[i]) begin mval[i] = vals[i]; mseen[i] = 1; end
        end
        @(negedge clk);
        smp_valid = '0;
        smp_data  = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic push_one(int idx, int v);
        int vals [N];
        for (int i = 0; i < N; i++) vals[i] = 0;
        vals[idx] = v;
        push(N'(1) << idx, vals);
    endtask

    task automatic push_all(int v);
        int vals [N];
        for (int i = 0; i < N; i++) vals[i] = v;
        push('1, vals);
    endtask

    task automatic check_reads(string tag);
        int v;
        for (int i = 0; i < N; i++) begin
            rd(i, v);
            check({tag, " R1 sensor"}, v, mseen[i] ? mval[i] : 0);
        end
        rd(9, v);  check({tag, " R2 peak"}, v, exp_peak());
        rd(10, v); check({tag, " R3 avg"}, v, exp_avg());
        for (int a = 11; a < 16; a++) begin
            rd(a, v); check({tag, " R4 reserved"}, v, 0);
        end
    endtask

    task automatic check_resp(string req, int a, int h);
        check({req, " alert"}, int'(vf_reduce_req), a);
        check({req, " clkgen_off"}, int'(clkgen_off), h);
        check({req, " vreg_off"}, int'(vreg_off), h);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < N; i++) begin mval[i] = 0; mseen[i] = 0; end
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] lfsr;
        int v;
        int vals [N];
        for (int i = 0; i < N; i++) begin mval[i] = 0; mseen[i] = 0; end
        do_reset();

        // R9: reset state, with thresholds at zero yet no sensor reported (R5, R7).
        repeat (4) @(negedge clk);
        check_reads("R9 reset");
        check_resp("R9 R5 R7 empty", 0, 0);

        alert_level = 255; hyst_amount = 0; crit_level = 255;

        // R8: latency, sample visible one edge after strobe, peak one more.
        @(negedge clk);
        smp_valid = 9'b000010000; smp_data[4*W +: W] = 8'd42;
        @(negedge clk);
        smp_valid = '0; smp_data = '0;
        mval[4] = 42; mseen[4] = 1;
        rd(4, v); check("R8 sensor after one edge", v, 42);
        rd(9, v); check("R8 peak not yet", v, 0);
        @(negedge clk);
        rd(9, v);  check("R8 peak after two edges", v, 42);
        rd(10, v); check("R3 single-sensor avg", v, 42);
        repeat (3) @(negedge clk);
        check_reads("R1 one sensor");

        // R3: grow the population one sensor at a time.
        for (int k = 0; k < N; k++) begin
            if (k != 4) begin
                push_one(k, 10 + 23 * k);
                check_reads("R3 growth");
            end
        end

        // R1/R2/R3 sweep: pseudo-random subsets and values.
        do_reset();
        lfsr = 16'hACE1;
        for (int p = 0; p < 60; p++) begin
            logic [N-1:0] mask;
            for (int i = 0; i < N; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                vals[i] = int'(lfsr[7:0]);
                if (vals[i] > 250) vals[i] = 250;
            end
            mask = lfsr[8:0] & ((p < 8) ? 9'h00F : 9'h1FF);
            push(mask, vals);
            check_reads("R1 R2 R3 sweep");
            check_resp("R5 R7 below thresholds", 0, 0);
        end

        // R5/R6: hysteresis walk.
        alert_level = 80; hyst_amount = 5; crit_level = 200;
        push_all(70);
        check_resp("R5 below level", 0, 0);
        push_one(3, 80); check_resp("R5 at level sets", 1, 0);
        push_one(3, 76); check_resp("R6 inside band holds", 1, 0);
        push_one(3, 75); check_resp("R6 at release holds", 1, 0);
        push_one(3, 74); check_resp("R6 below release clears", 0, 0);
        push_one(3, 79); check_resp("R5 no set below level", 0, 0);
        push_one(3, 80); check_resp("R5 resets at level", 1, 0);
        check_reads("R2 hysteresis peak");

        // R6: hysteresis larger than level saturates the release point at zero.
        alert_level = 3; hyst_amount = 10;
        push_all(5);  check_resp("R6 saturate set", 1, 0);
        push_all(0);  check_resp("R6 saturate holds", 1, 0);

        // R7: critical limit and stickiness.
        alert_level = 80; hyst_amount = 5; crit_level = 100;
        push_one(2, 99);  check_resp("R7 below crit", 1, 0);
        push_one(2, 100); check_resp("R7 at crit", 1, 1);
        push_all(20);     check_resp("R7 sticky after cooling", 0, 1);
        check_reads("R2 R3 after cooling");

        // R9: reset releases the sticky shutdown.
        do_reset();
        repeat (4) @(negedge clk);
        check_resp("R9 reset clears", 0, 0);
        check_reads("R9 after second reset");

        summary();
    end
endmodule